// File: doc/BRIEF.md
# Register-Mapped Stream Gate Unit

This block sits between a processor datapath and a set of per-channel word queues. Two input gates and two output gates look like registers to the processor. Reading an input gate takes the oldest word of the incoming channel the gate is attached to. Writing an output gate appends a word to the attached outgoing channel. The processor is held with `stall` whenever the gate it touches cannot complete: an empty channel on a read, or a full channel on a write. Software can reattach any gate to any channel of the same direction while the block runs. Words already queued on a channel stay there until a later reader collects them.

A spool engine drains an incoming channel into local memory without help from the processor. It is loaded with a channel number, a start address, a signed address step and a word count. It then issues one memory write for each word it moves, but only in cycles where the processor is not using memory. When its count is used up it raises a done flag. The block also flags each channel that turns from empty to non-empty, so that the compute side learns a new message has started to arrive.

Top module: `stream_gate_unit`

## Requirements
- R1: After reset every queue is empty (`net_in_full` all 0, `net_out_empty` all 1), `sp_done`, `mem_req` and `arrive_evt` are 0, and input and output gate g (0 or 1) are each attached to channel g.
- R2: A read of an input gate that does not stall returns, in the same cycle on `rd_data`, the oldest word of the attached incoming channel and removes it. Successive reads return words in arrival order.
- R3: A write to an output gate that does not stall appends `wr_data` to the attached outgoing channel. `net_out_data` shows the oldest word of channel `net_out_ch`, and `net_out_pop` removes it.
- R4: A read of an input gate whose attached channel is empty raises `stall` in that cycle and consumes nothing. When an instruction both reads and writes and either part stalls, neither part takes effect.
- R5: A write to an output gate whose attached channel holds DEPTH words raises `stall` and does not append the word.
- R6: `bind_en` with `bind_dir` (0 = input gate, 1 = output gate), `bind_gate` and `bind_ch` reattaches that gate from the next cycle onward. Words left unread on the previous channel remain queued.
- R7: `arrive_evt[c]` is high for exactly one cycle, the cycle after a push into channel c while c was empty. A push into a channel that already holds words raises no event.
- R8: After `sp_start`, the spool engine writes the words of incoming channel `sp_ch` in arrival order to `sp_base`, `sp_base+sp_stride`, `sp_base+2*sp_stride` and so on. The step is a two's-complement value of the address width. At most one word moves per cycle, and each move is shown by `mem_req` together with `mem_addr` and `mem_wdata`.
- R9: In any cycle with `cpu_mem_req` high, `mem_req` is low. The spool engine retries in a later cycle and loses no word.
- R10: `sp_done` rises after `sp_count` words have been written and stays high until the next `sp_start`. A start with a count of zero sets `sp_done` in the next cycle. A start with a non-zero count clears it.
- R11: A push on `net_in_valid` into an incoming channel that already holds DEPTH words (`net_in_full` high) is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Processor reads an input gate |
| rd_gate | input | 1 | Input gate selected for the read |
| rd_data | output | DW | Word returned by the read |
| wr_en | input | 1 | Processor writes an output gate |
| wr_gate | input | 1 | Output gate selected for the write |
| wr_data | input | DW | Word written |
| stall | output | 1 | Processor access cannot complete this cycle |
| bind_en | input | 1 | Reattach a gate |
| bind_dir | input | 1 | 0 input gate, 1 output gate |
| bind_gate | input | 1 | Gate to reattach |
| bind_ch | input | log2(NCH) | New channel for the gate |
| net_in_valid | input | 1 | Network pushes a word into an incoming channel |
| net_in_ch | input | log2(NCH) | Incoming channel written |
| net_in_data | input | DW | Incoming word |
| net_in_full | output | NCH | Incoming channel full flags |
| net_out_pop | input | 1 | Network removes a word from an outgoing channel |
| net_out_ch | input | log2(NCH) | Outgoing channel read |
| net_out_data | output | DW | Oldest word of that outgoing channel |
| net_out_empty | output | NCH | Outgoing channel empty flags |
| arrive_evt | output | NCH | New-message event per incoming channel |
| sp_start | input | 1 | Load and start the spool engine |
| sp_ch | input | log2(NCH) | Incoming channel to drain |
| sp_base | input | AW | First memory address |
| sp_stride | input | AW | Signed address step |
| sp_count | input | CW | Number of words to move |
| sp_done | output | 1 | Spool count exhausted |
| cpu_mem_req | input | 1 | Processor uses memory this cycle |
| mem_req | output | 1 | Spool memory write this cycle |
| mem_addr | output | AW | Spool write address |
| mem_wdata | output | DW | Spool write data |

## Verification
Gate reads, the stall flag, `net_out_data` and the spool memory request are combinational, so they are due in the very cycle the stimulus is applied. Queue contents, bindings, `arrive_evt` and `sp_done` change at the next clock edge, so they are due one cycle later. The bench drives inputs on the falling edge and samples 2 ns later, before the rising edge that commits them. Expected read words and memory writes wait in scoreboard queues. A monitor pops one entry only in a cycle where the access really completes, so a missing stall or an extra move shows up as a mismatch or as a leftover entry.

// File: rtl/gsu_pkg.sv
`timescale 1ns/1ps
package gsu_pkg;
    localparam int unsigned DEF_DW    = 16;
    localparam int unsigned DEF_NCH   = 4;
    localparam int unsigned DEF_DEPTH = 4;
    localparam int unsigned DEF_AW    = 12;
    localparam int unsigned DEF_CW    = 8;
    localparam int unsigned NUM_GATES = 2;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } gate_dir_e;

    // index width that never collapses to zero
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/gsu_fifo.sv
`timescale 1ns/1ps
module gsu_fifo #(
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          empty
);
    localparam int unsigned PW = gsu_pkg::idx_w(DEPTH);
    localparam int unsigned CNTW = $clog2(DEPTH + 1);

    logic [DW-1:0]   store [DEPTH];
    logic [PW-1:0]   rd_ptr, wr_ptr;
    logic [CNTW-1:0] fill;
    logic            do_push, do_pop;

    assign full    = (fill == CNTW'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                store[wr_ptr] <= din;
                wr_ptr        <= bump(wr_ptr);
            end
            if (do_pop) rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/gsu_spool.sv
`timescale 1ns/1ps
module gsu_spool #(
    parameter int unsigned AW  = 12,
    parameter int unsigned CW  = 8,
    parameter int unsigned CHW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [AW-1:0]  cfg_base,
    input  logic [AW-1:0]  cfg_stride,
    input  logic [CW-1:0]  cfg_count,
    input  logic           src_ready,
    input  logic           cpu_busy,
    output logic           req,
    output logic [AW-1:0]  addr,
    output logic [CHW-1:0] cur_ch,
    output logic           done
);
    logic          active;
    logic [AW-1:0] step;
    logic [CW-1:0] remain;

    // processor has priority on the memory port
    assign req = active && src_ready && !cpu_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            done   <= 1'b0;
            addr   <= '0;
            step   <= '0;
            remain <= '0;
            cur_ch <= '0;
        end else if (start) begin
            cur_ch <= cfg_ch;
            addr   <= cfg_base;
            step   <= cfg_stride;
            remain <= cfg_count;
            active <= (cfg_count != '0);
            done   <= (cfg_count == '0);
        end else if (req) begin
            addr   <= addr + step;
            remain <= remain - 1'b1;
            if (remain == CW'(1)) begin
                active <= 1'b0;
                done   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/stream_gate_unit.sv
`timescale 1ns/1ps
module stream_gate_unit
    import gsu_pkg::*;
#(
    parameter int unsigned DW    = DEF_DW,
    parameter int unsigned NCH   = DEF_NCH,
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned AW    = DEF_AW,
    parameter int unsigned CW    = DEF_CW,
    localparam int unsigned CHW  = idx_w(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_en,
    input  logic           rd_gate,
    output logic [DW-1:0]  rd_data,
    input  logic           wr_en,
    input  logic           wr_gate,
    input  logic [DW-1:0]  wr_data,
    output logic           stall,
    input  logic           bind_en,
    input  logic           bind_dir,
    input  logic           bind_gate,
    input  logic [CHW-1:0] bind_ch,
    input  logic           net_in_valid,
    input  logic [CHW-1:0] net_in_ch,
    input  logic [DW-1:0]  net_in_data,
    output logic [NCH-1:0] net_in_full,
    input  logic           net_out_pop,
    input  logic [CHW-1:0] net_out_ch,
    output logic [DW-1:0]  net_out_data,
    output logic [NCH-1:0] net_out_empty,
    output logic [NCH-1:0] arrive_evt,
    input  logic           sp_start,
    input  logic [CHW-1:0] sp_ch,
    input  logic [AW-1:0]  sp_base,
    input  logic [AW-1:0]  sp_stride,
    input  logic [CW-1:0]  sp_count,
    output logic           sp_done,
    input  logic           cpu_mem_req,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata
);
    logic [CHW-1:0] in_bind  [NUM_GATES];
    logic [CHW-1:0] out_bind [NUM_GATES];

    logic [DW-1:0]  in_head  [NCH];
    logic [DW-1:0]  out_head [NCH];
    logic [NCH-1:0] in_empty, out_full;

    logic [CHW-1:0] rd_ch, wr_ch, sp_cur;
    logic           rd_block, wr_block, proc_pop, proc_push, sp_ready;

    assign rd_ch     = in_bind[rd_gate];
    assign wr_ch     = out_bind[wr_gate];
    assign rd_block  = rd_en && in_empty[rd_ch];
    assign wr_block  = wr_en && out_full[wr_ch];
    assign stall     = rd_block || wr_block;
    assign proc_pop  = rd_en && !stall;
    assign proc_push = wr_en && !stall;
    assign rd_data   = in_head[rd_ch];
    assign net_out_data = out_head[net_out_ch];

    // the processor read wins a channel the spool engine also drains
    assign sp_ready  = !in_empty[sp_cur] && !(proc_pop && rd_ch == sp_cur);
    assign mem_wdata = in_head[sp_cur];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < NUM_GATES; g++) begin
                in_bind[g]  <= CHW'(g);
                out_bind[g] <= CHW'(g);
            end
        end else if (bind_en) begin
            if (gate_dir_e'(bind_dir) == DIR_OUT) out_bind[bind_gate] <= bind_ch;
            else                                  in_bind[bind_gate]  <= bind_ch;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic in_push, in_pop, out_push, out_pop, out_empty_c;

        assign in_push  = net_in_valid && (net_in_ch == CHW'(c));
        assign in_pop   = (proc_pop && rd_ch == CHW'(c)) ||
                          (mem_req && sp_cur == CHW'(c));
        assign out_push = proc_push && (wr_ch == CHW'(c));
        assign out_pop  = net_out_pop && (net_out_ch == CHW'(c));

        gsu_fifo #(.DW(DW), .DEPTH(DEPTH)) u_inq (
            .clk(clk), .rst(rst),
            .push(in_push), .din(net_in_data), .pop(in_pop),
            .dout(in_head[c]), .full(net_in_full[c]), .empty(in_empty[c])
        );

        gsu_fifo #(.DW(DW), .DEPTH(DEPTH)) u_outq (
            .clk(clk), .rst(rst),
            .push(out_push), .din(wr_data), .pop(out_pop),
            .dout(out_head[c]), .full(out_full[c]), .empty(out_empty_c)
        );
        assign net_out_empty[c] = out_empty_c;

        always_ff @(posedge clk) begin
            if (rst) arrive_evt[c] <= 1'b0;
            else     arrive_evt[c] <= in_push && in_empty[c];
        end
    end

    gsu_spool #(.AW(AW), .CW(CW), .CHW(CHW)) u_spool (
        .clk(clk), .rst(rst),
        .start(sp_start), .cfg_ch(sp_ch), .cfg_base(sp_base),
        .cfg_stride(sp_stride), .cfg_count(sp_count),
        .src_ready(sp_ready), .cpu_busy(cpu_mem_req),
        .req(mem_req), .addr(mem_addr), .cur_ch(sp_cur), .done(sp_done)
    );
endmodule

// File: rtl/gsu_chk.sv
`timescale 1ns/1ps
module gsu_chk #(
    parameter int unsigned NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           cpu_mem_req,
    input logic           mem_req,
    input logic           sp_done,
    input logic           sp_start,
    input logic           net_in_valid,
    input logic [NCH-1:0] arrive_evt
);
    // R9
    cpu_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_mem_req |-> !mem_req);

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sp_done && !sp_start) |=> sp_done);

    // R10
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        sp_done |-> !mem_req);

    // R7
    evt_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(arrive_evt));

    // R7
    evt_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (|arrive_evt) |-> $past(net_in_valid));

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sp_done && !mem_req && arrive_evt == '0));
endmodule

bind stream_gate_unit gsu_chk #(.NCH(NCH)) u_gsu_chk (
    .clk(clk), .rst(rst), .cpu_mem_req(cpu_mem_req), .mem_req(mem_req),
    .sp_done(sp_done), .sp_start(sp_start), .net_in_valid(net_in_valid),
    .arrive_evt(arrive_evt)
);

// File: tb/stream_gate_unit_bench.sv
`timescale 1ns/1ps
module stream_gate_unit_bench;
    localparam int DW = 16, NCH = 4, DEPTH = 4, AW = 12, CW = 8, CHW = 2;

    logic clk = 0, rst = 1;
    logic rd_en = 0, rd_gate = 0, wr_en = 0, wr_gate = 0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic stall;
    logic bind_en = 0, bind_dir = 0, bind_gate = 0;
    logic [CHW-1:0] bind_ch = '0;
    logic net_in_valid = 0;
    logic [CHW-1:0] net_in_ch = '0;
    logic [DW-1:0] net_in_data = '0;
    logic [NCH-1:0] net_in_full, net_out_empty, arrive_evt;
    logic net_out_pop = 0;
    logic [CHW-1:0] net_out_ch = '0;
    logic [DW-1:0] net_out_data;
    logic sp_start = 0;
    logic [CHW-1:0] sp_ch = '0;
    logic [AW-1:0] sp_base = '0, sp_stride = '0, mem_addr;
    logic [CW-1:0] sp_count = '0;
    logic sp_done, cpu_mem_req = 0, mem_req;
    logic [DW-1:0] mem_wdata;

    int tests = 0, fails = 0;
    bit finished = 0;
    logic [DW-1:0] exp_rd [$];
    logic [AW-1:0] exp_addr [$];
    logic [DW-1:0] exp_wd [$];

    always #4 clk = ~clk;

    stream_gate_unit #(.DW(DW), .NCH(NCH), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_stream_gate_unit (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: compare completed reads and spool writes
    initial forever begin
        @(negedge clk); #2;
        if (!rst && rd_en && !stall) begin
            if (exp_rd.size() == 0) chk(0, "R2 unexpected read", rd_data, 0);
            else begin
                logic [DW-1:0] e;
                e = exp_rd.pop_front();
                chk(rd_data == e, "R2 read data", rd_data, e);
            end
        end
        if (!rst && mem_req) begin
            if (exp_addr.size() == 0) chk(0, "R8 unexpected spool write", mem_addr, 0);
            else begin
                logic [AW-1:0] ea;
                logic [DW-1:0] ed;
                ea = exp_addr.pop_front();
                ed = exp_wd.pop_front();
                chk(mem_addr == ea, "R8 spool address", mem_addr, ea);
                chk(mem_wdata == ed, "R8 spool data", mem_wdata, ed);
            end
        end
    end

    task automatic push_in(input int ch, input logic [DW-1:0] d);
        @(negedge clk);
        net_in_valid = 1; net_in_ch = CHW'(ch); net_in_data = d;
        @(negedge clk);
        net_in_valid = 0;
    endtask

    task automatic read_gate(input bit g, input logic [DW-1:0] e);
        @(negedge clk);
        exp_rd.push_back(e);
        rd_en = 1; rd_gate = g;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic read_stall(input bit g, input string req);
        @(negedge clk);
        rd_en = 1; rd_gate = g;
        #2 chk(stall == 1, req, stall, 1);
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic write_gate(input bit g, input logic [DW-1:0] d, input bit expect_stall);
        @(negedge clk);
        wr_en = 1; wr_gate = g; wr_data = d;
        #2 chk(stall == expect_stall, "R5 write stall", stall, expect_stall);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic net_pop(input int ch, input logic [DW-1:0] e);
        @(negedge clk);
        net_out_ch = CHW'(ch);
        #2;
        chk(!net_out_empty[ch] && net_out_data == e, "R3 outgoing word", net_out_data, e);
        net_out_pop = 1;
        @(negedge clk);
        net_out_pop = 0;
    endtask

    task automatic do_bind(input bit dir, input bit g, input int ch);
        @(negedge clk);
        bind_en = 1; bind_dir = dir; bind_gate = g; bind_ch = CHW'(ch);
        @(negedge clk);
        bind_en = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #2;
        // R1 reset state
        chk(net_in_full == '0 && net_out_empty == '1, "R1 queues empty", {net_in_full, net_out_empty}, 8'h0f);
        chk(!sp_done && !mem_req && arrive_evt == '0 && !stall, "R1 flags clear", {sp_done, mem_req, arrive_evt}, 0);

        // R2 / R7: default bindings, order, arrival event
        push_in(0, 16'hA001);
        #2 chk(arrive_evt == 4'b0001, "R7 event on first word", arrive_evt, 1);
        push_in(0, 16'hA002);
        #2 chk(arrive_evt == 4'b0000, "R7 no event on non-empty", arrive_evt, 0);
        push_in(0, 16'hA003);
        push_in(1, 16'hB001);
        #2 chk(arrive_evt == 4'b0010, "R7 event channel 1", arrive_evt, 2);
        read_gate(0, 16'hA001);
        read_gate(0, 16'hA002);
        read_gate(1, 16'hB001);
        read_gate(0, 16'hA003);

        // R4: empty read stalls and consumes nothing
        read_stall(0, "R4 stall on empty");
        push_in(0, 16'hA004);
        read_gate(0, 16'hA004);

        // R3: output gate order
        write_gate(0, 16'hC001, 0);
        write_gate(0, 16'hC002, 0);
        net_pop(0, 16'hC001);
        net_pop(0, 16'hC002);
        #2 chk(net_out_empty[0] == 1, "R3 drained", net_out_empty[0], 1);

        // R5: full output channel
        for (int i = 0; i < DEPTH; i++) write_gate(1, 16'hF000 + DW'(i), 0);
        write_gate(1, 16'hFFFF, 1);
        for (int i = 0; i < DEPTH; i++) net_pop(1, 16'hF000 + DW'(i));
        #2 chk(net_out_empty[1] == 1, "R5 stalled word not added", net_out_empty[1], 1);

        // R6: rebinding keeps queued words
        push_in(2, 16'hD001);
        push_in(2, 16'hD002);
        do_bind(0, 0, 2);
        read_gate(0, 16'hD001);
        do_bind(0, 0, 0);
        do_bind(0, 1, 2);
        read_gate(1, 16'hD002);
        read_stall(1, "R6 channel 2 drained");
        do_bind(1, 0, 3);
        write_gate(0, 16'hE0E0, 0);
        #2 chk(net_out_empty == 4'b0111, "R6 output rebind target", net_out_empty, 4'b0111);
        net_pop(3, 16'hE0E0);

        // R11: push into full incoming channel dropped
        for (int i = 0; i <= DEPTH; i++) push_in(3, 16'h3000 + DW'(i));
        #2 chk(net_in_full[3] == 1, "R11 full flag", net_in_full[3], 1);
        do_bind(0, 1, 3);
        for (int i = 0; i < DEPTH; i++) read_gate(1, 16'h3000 + DW'(i));
        read_stall(1, "R11 extra word dropped");
        do_bind(0, 1, 1);

        // R8 / R9 / R10: spool with processor collision
        push_in(1, 16'h5001);
        push_in(1, 16'h5002);
        push_in(1, 16'h5003);
        exp_addr.push_back(12'd100); exp_wd.push_back(16'h5001);
        exp_addr.push_back(12'd96);  exp_wd.push_back(16'h5002);
        exp_addr.push_back(12'd92);  exp_wd.push_back(16'h5003);
        @(negedge clk);
        sp_start = 1; sp_ch = 1; sp_base = 12'd100; sp_stride = 12'hFFC; sp_count = 3;
        cpu_mem_req = 1;
        @(negedge clk);
        sp_start = 0;
        #2 chk(mem_req == 0, "R9 processor wins memory", mem_req, 0);
        chk(sp_done == 0, "R10 done clear while busy", sp_done, 0);
        @(negedge clk);
        cpu_mem_req = 0;
        repeat (5) @(negedge clk);
        #2;
        chk(sp_done == 1, "R10 done after count", sp_done, 1);
        chk(exp_addr.size() == 0, "R9 no word lost", exp_addr.size(), 0);
        read_stall(1, "R8 spool drained channel");

        // R10: non-zero start clears done, zero count sets it
        @(negedge clk);
        sp_start = 1; sp_count = 2;
        @(negedge clk);
        sp_start = 0;
        #2 chk(sp_done == 0, "R10 start clears done", sp_done, 0);
        @(negedge clk);
        sp_start = 1; sp_count = 0;
        @(negedge clk);
        sp_start = 0;
        #2 chk(sp_done == 1 && mem_req == 0, "R10 zero count", sp_done, 1);

        repeat (2) @(negedge clk);
        chk(exp_rd.size() == 0, "R2 all reads completed", exp_rd.size(), 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule